// File: doc/BRIEF.md
# Quad-Pair Fragment Layout Converter

This block sits between a matrix source and a 32-lane register file. It covers a half-precision 8x8x4 multiply scheme in which one warp runs four independent multiplies, and each multiply is served by a low quad and a high quad of four lanes. The block takes matrix writes one element per cycle, each as (computation, row, column, value). For each write it works out which lane and which register slot the element belongs in, and stores it in a 32-lane image. That image can then be read out one lane at a time.

The opposite direction works through the same position logic. An element request carries (computation, row, column) and returns the stored value, so a caller can walk a finished image back out as a matrix stream. A static configuration picks the operand kind and, for operands A and B, the storage order. The arithmetic of the multiply and any memory addressing are left to neighbouring blocks. A flush strobe marks the image as complete.

Top module: `qfc_frag_conv`

## Requirements
- R1: Computation n (0..3, from `wr_comp`/`el_comp`) occupies only lanes 4n..4n+3 (low quad) and 16+4n..16+4n+3 (high quad). Quad position t = lane mod 4, and h = 1 for lanes 16 and above.
- R2: With `cfg_kind`=0 (operand A) and `cfg_col_major`=0, lane element i holds A[t+4h][i], for i = 0..3.
- R3: With `cfg_kind`=0 and `cfg_col_major`=1, lane element i holds A[i+4h][t].
- R4: With `cfg_kind`=1 (operand B, 4 rows by 8 columns) and `cfg_col_major`=0, lane element i holds B[t][i+4h].
- R5: With `cfg_kind`=1 and `cfg_col_major`=1, lane element i holds B[i][t+4h].
- R6: With `cfg_kind`=2 (16-bit accumulator), lane element i (0..7) holds C[t+4h][i]. `cfg_col_major` has no effect.
- R7: With `cfg_kind`=3 (32-bit accumulator), lane element i (0..7) sits in register i and holds C[(lane&1)+(i&2)+4h][(i&4)+(lane&2)+(i&1)].
- R8: In 16-bit kinds (0, 1, 2) the value is `wr_data[15:0]`. Element i goes to register i/2: bits 15:0 when i is even, bits 31:16 when i is odd. The other half of that register is left unchanged.
- R9: A write with a column of 4 or more for A, or a row of 4 or more for B, is accepted and changes no lane. An element request at such a coordinate returns 0.
- R10: `wr_ready` is 0 in any cycle with `flush` high, and 1 otherwise. `img_done` becomes 1 the cycle after a flush and 0 the cycle after an accepted write. Otherwise it holds its value.
- R11: A lane request (`rd_req`) raises `rd_vld` in the next cycle. `rd_regs[32k+31:32k]` then carries register k of lane `rd_lane`. With no request, `rd_vld` is 0.
- R12: An element request (`el_req`) raises `el_vld` in the next cycle. `el_data` then carries the stored element, zero-extended in the 16-bit kinds.
- R13: While reset is asserted, `rd_vld`, `el_vld` and `img_done` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| cfg_kind | input | 2 | 0 = A, 1 = B, 2 = 16-bit accumulator, 3 = 32-bit accumulator |
| cfg_col_major | input | 1 | Column-major storage order for A or B |
| wr_valid | input | 1 | Element write request |
| wr_ready | output | 1 | Write accepted this cycle |
| wr_comp | input | 2 | Computation index of the write |
| wr_row | input | 3 | Matrix row of the write |
| wr_col | input | 3 | Matrix column of the write |
| wr_data | input | 32 | Element value |
| flush | input | 1 | Marks the image complete |
| img_done | output | 1 | Image complete since the last accepted write |
| rd_req | input | 1 | Lane image read request |
| rd_lane | input | 5 | Lane to read |
| rd_vld | output | 1 | Lane data valid |
| rd_regs | output | 256 | Eight 32-bit registers of the lane |
| el_req | input | 1 | Element readback request |
| el_comp | input | 2 | Computation index to read |
| el_row | input | 3 | Matrix row to read |
| el_col | input | 3 | Matrix column to read |
| el_vld | output | 1 | Element data valid |
| el_data | output | 32 | Element value read back |

## Verification
The bench fills random matrices in all six layouts and reads every lane back. Each slot is compared with values placed by the forward lane-to-coordinate equations, so a swapped low/high quad, a missing +4 offset in the high group, or a wrong interleaved bit in the 32-bit accumulator shows up as a value in the wrong slot. Writing neighbouring 16-bit elements one after the other catches a half-register write that wipes its partner. Out-of-range writes for A and B that clobber a lane show up as corrupted images, and element readback exposes a reverse path that does not agree with the forward one. Flush and write checks catch an `img_done` flag that fails to clear or does not hold off the write.

// File: rtl/qfc_pkg.sv
package qfc_pkg;
  typedef enum logic [1:0] {
    KIND_A     = 2'd0,
    KIND_B     = 2'd1,
    KIND_ACC16 = 2'd2,
    KIND_ACC32 = 2'd3
  } kind_e;

  localparam int unsigned QUAD_LANES = 4;
  localparam int unsigned NUM_COMPS  = 4;
endpackage

// File: rtl/qfc_coord_map.sv
// Maps a matrix coordinate of one computation to its lane, register and half.
module qfc_coord_map
  import qfc_pkg::*;
(
  input  kind_e      kind,
  input  logic       col_major,
  input  logic [1:0] comp,
  input  logic [2:0] row,
  input  logic [2:0] col,
  output logic [4:0] lane,
  output logic [2:0] reg_idx,
  output logic       upper,
  output logic       wide,
  output logic       legal
);
  logic       hi_grp;
  logic [1:0] quad_pos;
  logic [2:0] elem;

  always_comb begin
    hi_grp   = row[2];
    quad_pos = row[1:0];
    elem     = col;
    legal    = 1'b1;
    unique case (kind)
      KIND_A: begin
        legal  = ~col[2];
        hi_grp = row[2];
        if (col_major) begin
          quad_pos = col[1:0];
          elem     = {1'b0, row[1:0]};
        end else begin
          quad_pos = row[1:0];
          elem     = {1'b0, col[1:0]};
        end
      end
      KIND_B: begin
        legal  = ~row[2];
        hi_grp = col[2];
        if (col_major) begin
          quad_pos = col[1:0];
          elem     = {1'b0, row[1:0]};
        end else begin
          quad_pos = row[1:0];
          elem     = {1'b0, col[1:0]};
        end
      end
      KIND_ACC16: begin
        hi_grp   = row[2];
        quad_pos = row[1:0];
        elem     = col;
      end
      default: begin
        // interleaved 32-bit accumulator: lane bits from row[0], col[1]
        hi_grp   = row[2];
        quad_pos = {col[1], row[0]};
        elem     = {col[2], row[1], col[0]};
      end
    endcase
  end

  assign wide    = (kind == KIND_ACC32);
  assign lane    = {hi_grp, comp, quad_pos};
  assign reg_idx = wide ? elem : {1'b0, elem[2:1]};
  assign upper   = ~wide & elem[0];
endmodule

// File: rtl/qfc_lane_store.sv
// Lane register image with a half-word write port and two read ports.
module qfc_lane_store #(
  parameter int unsigned LANES  = 32,
  parameter int unsigned REGS   = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned HALF_W = DATA_W / 2,
  localparam int unsigned LANE_W = $clog2(LANES),
  localparam int unsigned REG_W  = $clog2(REGS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [LANE_W-1:0]      we_lane,
  input  logic [REG_W-1:0]       we_reg,
  input  logic                   we_wide,
  input  logic                   we_upper,
  input  logic [DATA_W-1:0]      we_data,
  input  logic                   rd_req,
  input  logic [LANE_W-1:0]      rd_lane,
  output logic                   rd_vld,
  output logic [REGS*DATA_W-1:0] rd_regs,
  input  logic                   el_req,
  input  logic                   el_ok,
  input  logic [LANE_W-1:0]      el_lane,
  input  logic [REG_W-1:0]       el_reg,
  input  logic                   el_wide,
  input  logic                   el_upper,
  output logic                   el_vld,
  output logic [DATA_W-1:0]      el_data
);
  logic [DATA_W-1:0]      mem [LANES][REGS];
  logic [REGS*DATA_W-1:0] rd_regs_d;
  logic [DATA_W-1:0]      el_word;
  logic [DATA_W-1:0]      el_data_d;
  logic                   rd_vld_q, el_vld_q;

  always_ff @(posedge clk) begin
    if (we) begin
      if (we_wide)
        mem[we_lane][we_reg] <= we_data;
      else if (we_upper)
        mem[we_lane][we_reg][DATA_W-1:HALF_W] <= we_data[HALF_W-1:0];
      else
        mem[we_lane][we_reg][HALF_W-1:0] <= we_data[HALF_W-1:0];
    end
  end

  always_comb begin
    for (int r = 0; r < REGS; r++)
      rd_regs_d[r*DATA_W +: DATA_W] = mem[rd_lane][r];
  end

  always_comb begin
    el_word = mem[el_lane][el_reg];
    if (!el_ok)
      el_data_d = '0;
    else if (el_wide)
      el_data_d = el_word;
    else if (el_upper)
      el_data_d = {{HALF_W{1'b0}}, el_word[DATA_W-1:HALF_W]};
    else
      el_data_d = {{HALF_W{1'b0}}, el_word[HALF_W-1:0]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_vld_q <= 1'b0;
      el_vld_q <= 1'b0;
    end else begin
      rd_vld_q <= rd_req;
      el_vld_q <= el_req;
    end
  end

  always_ff @(posedge clk) begin
    if (rd_req) rd_regs <= rd_regs_d;
    if (el_req) el_data <= el_data_d;
  end

  assign rd_vld = rd_vld_q;
  assign el_vld = el_vld_q;
endmodule

// File: rtl/qfc_frag_conv.sv
module qfc_frag_conv
  import qfc_pkg::*;
#(
  parameter int unsigned LANES  = 32,
  parameter int unsigned REGS   = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANE_W = $clog2(LANES),
  localparam int unsigned REG_W  = $clog2(REGS)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             cfg_kind,
  input  logic                   cfg_col_major,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  input  logic [1:0]             wr_comp,
  input  logic [2:0]             wr_row,
  input  logic [2:0]             wr_col,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic                   flush,
  output logic                   img_done,
  input  logic                   rd_req,
  input  logic [LANE_W-1:0]      rd_lane,
  output logic                   rd_vld,
  output logic [REGS*DATA_W-1:0] rd_regs,
  input  logic                   el_req,
  input  logic [1:0]             el_comp,
  input  logic [2:0]             el_row,
  input  logic [2:0]             el_col,
  output logic                   el_vld,
  output logic [DATA_W-1:0]      el_data
);
  kind_e             kind;
  logic [LANE_W-1:0] w_lane, e_lane;
  logic [REG_W-1:0]  w_reg, e_reg;
  logic              w_upper, w_wide, w_legal;
  logic              e_upper, e_wide, e_legal;
  logic              accept, store_we;
  logic              done_q, done_d;

  assign kind = kind_e'(cfg_kind);

  qfc_coord_map u_wr_map (
    .kind(kind), .col_major(cfg_col_major), .comp(wr_comp),
    .row(wr_row), .col(wr_col), .lane(w_lane), .reg_idx(w_reg),
    .upper(w_upper), .wide(w_wide), .legal(w_legal)
  );

  qfc_coord_map u_el_map (
    .kind(kind), .col_major(cfg_col_major), .comp(el_comp),
    .row(el_row), .col(el_col), .lane(e_lane), .reg_idx(e_reg),
    .upper(e_upper), .wide(e_wide), .legal(e_legal)
  );

  assign wr_ready = ~flush;
  assign accept   = wr_valid & wr_ready;
  assign store_we = accept & w_legal;

  qfc_lane_store #(.LANES(LANES), .REGS(REGS), .DATA_W(DATA_W)) u_store (
    .clk(clk), .rst_n(rst_n),
    .we(store_we), .we_lane(w_lane), .we_reg(w_reg), .we_wide(w_wide),
    .we_upper(w_upper), .we_data(wr_data),
    .rd_req(rd_req), .rd_lane(rd_lane), .rd_vld(rd_vld), .rd_regs(rd_regs),
    .el_req(el_req), .el_ok(e_legal), .el_lane(e_lane), .el_reg(e_reg),
    .el_wide(e_wide), .el_upper(e_upper), .el_vld(el_vld), .el_data(el_data)
  );

  always_comb begin
    done_d = done_q;
    if (flush)       done_d = 1'b1;
    else if (accept) done_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) done_q <= 1'b0;
    else        done_q <= done_d;
  end

  assign img_done = done_q;
endmodule

// File: rtl/qfc_frag_conv_chk.sv
module qfc_frag_conv_chk #(
  parameter int unsigned LANES  = 32,
  parameter int unsigned REGS   = 8,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANE_W = $clog2(LANES)
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [1:0]             cfg_kind,
  input logic                   cfg_col_major,
  input logic                   wr_valid,
  input logic                   wr_ready,
  input logic [1:0]             wr_comp,
  input logic [2:0]             wr_row,
  input logic [2:0]             wr_col,
  input logic [DATA_W-1:0]      wr_data,
  input logic                   flush,
  input logic                   img_done,
  input logic                   rd_req,
  input logic [LANE_W-1:0]      rd_lane,
  input logic                   rd_vld,
  input logic [REGS*DATA_W-1:0] rd_regs,
  input logic                   el_req,
  input logic [1:0]             el_comp,
  input logic [2:0]             el_row,
  input logic [2:0]             el_col,
  input logic                   el_vld,
  input logic [DATA_W-1:0]      el_data
);
  AST_LANE_RD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> rd_vld); // R11
  AST_LANE_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_req |=> !rd_vld); // R11
  AST_EL_RD_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    el_req |=> el_vld); // R12
  AST_FLUSH_SETS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> img_done); // R10
  AST_WRITE_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready) |=> !img_done); // R10
  AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!flush && !(wr_valid && wr_ready)) |=> $stable(img_done)); // R10
endmodule

bind qfc_frag_conv qfc_frag_conv_chk #(.LANES(LANES), .REGS(REGS), .DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_qfc_frag_conv.sv
module test_qfc_frag_conv;
  logic         clk;
  logic         rst_n;
  logic [1:0]   cfg_kind;
  logic         cfg_col_major;
  logic         wr_valid, wr_ready;
  logic [1:0]   wr_comp;
  logic [2:0]   wr_row, wr_col;
  logic [31:0]  wr_data;
  logic         flush, img_done;
  logic         rd_req;
  logic [4:0]   rd_lane;
  logic         rd_vld;
  logic [255:0] rd_regs;
  logic         el_req;
  logic [1:0]   el_comp;
  logic [2:0]   el_row, el_col;
  logic         el_vld;
  logic [31:0]  el_data;

  int total = 0;
  int bad   = 0;
  bit finished = 0;
  logic [31:0] mat [4][8][8];

  typedef struct {
    int          lane;
    logic [31:0] exp [8];
    logic [7:0]  mask;
    string       tag;
  } lane_exp_t;
  lane_exp_t sb [$];

  qfc_frag_conv i_qfc_frag_conv (.*);

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  // forward equations: lane slot i -> matrix coordinate
  function automatic void lane_coord(input int kind, input bit cm, input int lane,
                                     input int i, output int row, output int col);
    int h, t;
    h = (lane >= 16) ? 4 : 0;
    t = lane % 4;
    case (kind)
      0: if (!cm) begin row = t + h; col = i; end
         else     begin row = i % 4 + h; col = t; end
      1: if (!cm) begin row = t; col = i + h; end
         else     begin row = i; col = t + h; end
      2: begin row = t + h; col = i; end
      default: begin
        row = (lane & 1) + (i & 2) + h;
        col = (i & 4) + (lane & 2) + (i & 1);
      end
    endcase
  endfunction

  task automatic wr_one(input int n, input int r, input int c, input logic [31:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_comp = 2'(n); wr_row = 3'(r); wr_col = 3'(c); wr_data = d;
  endtask

  task automatic fill(input int kind);
    int rows, cols;
    bit first;
    rows = (kind == 1) ? 4 : 8;
    cols = (kind == 0) ? 4 : 8;
    first = 1;
    for (int n = 0; n < 4; n++)
      for (int r = 0; r < rows; r++)
        for (int c = 0; c < cols; c++) begin
          mat[n][r][c] = $urandom;
          wr_one(n, r, c, mat[n][r][c]);
          if (first) begin
            first = 0;
            @(negedge clk);
            wr_valid = 1'b0;
            check(img_done == 1'b0, "R10", "done after write", 32'(img_done), 32'd0);
          end
        end
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1'b1;
    #1 check(wr_ready == 1'b0, "R10", "ready in flush", 32'(wr_ready), 32'd0);
    @(negedge clk);
    flush = 1'b0;
    check(img_done == 1'b1, "R10", "done after flush", 32'(img_done), 32'd1);
  endtask

  task automatic read_lanes(input int kind, input bit cm, input string tag);
    int ne, row, col;
    lane_exp_t e;
    ne = (kind >= 2) ? 8 : 4;
    for (int l = 0; l < 32; l++) begin
      e.lane = l;
      e.tag  = tag;
      e.mask = '0;
      for (int k = 0; k < 8; k++) e.exp[k] = '0;
      for (int i = 0; i < ne; i++) begin
        logic [31:0] v;
        lane_coord(kind, cm, l, i, row, col);
        v = mat[(l >> 2) & 3][row][col];
        if (kind == 3) begin
          e.exp[i] = v;
          e.mask[i] = 1'b1;
        end else begin
          e.exp[i >> 1][(i & 1) * 16 +: 16] = v[15:0];
          e.mask[i >> 1] = 1'b1;
        end
      end
      @(negedge clk);
      rd_req = 1'b1;
      rd_lane = 5'(l);
      sb.push_back(e);
    end
    @(negedge clk);
    rd_req = 1'b0;
    repeat (3) @(negedge clk);
    check(sb.size() == 0, tag, "lane responses missing", 32'(sb.size()), 32'd0);
  endtask

  // monitor: compare each lane response with the scoreboard head
  always @(negedge clk) begin
    if (rst_n && rd_vld) begin
      if (sb.size() == 0) begin
        check(1'b0, "R11", "unexpected lane response", 32'd1, 32'd0);
      end else begin
        lane_exp_t e;
        e = sb.pop_front();
        for (int k = 0; k < 8; k++)
          if (e.mask[k])
            check(rd_regs[k*32 +: 32] === e.exp[k], e.tag,
                  $sformatf("lane %0d reg %0d", e.lane, k), rd_regs[k*32 +: 32], e.exp[k]);
      end
    end
  end

  task automatic el_check(input int n, input int r, input int c,
                          input logic [31:0] exp, input string tag);
    @(negedge clk);
    el_req = 1'b1; el_comp = 2'(n); el_row = 3'(r); el_col = 3'(c);
    @(negedge clk);
    el_req = 1'b0;
    check(el_vld == 1'b1, "R12", "element valid", 32'(el_vld), 32'd1);
    check(el_data === exp, tag, $sformatf("element %0d/%0d/%0d", n, r, c), el_data, exp);
  endtask

  task automatic run_mode(input int kind, input bit cm, input string tag);
    int rows, cols;
    @(negedge clk);
    cfg_kind = 2'(kind);
    cfg_col_major = cm;
    fill(kind);
    // R9: out-of-range writes must leave every lane untouched
    if (kind == 0) for (int c = 4; c < 8; c++) wr_one(c - 4, 1, c, $urandom);
    if (kind == 1) for (int r = 4; r < 8; r++) wr_one(r - 4, r, 2, $urandom);
    @(negedge clk);
    wr_valid = 1'b0;
    do_flush();
    read_lanes(kind, cm, tag);
    rows = (kind == 1) ? 4 : 8;
    cols = (kind == 0) ? 4 : 8;
    for (int j = 0; j < 6; j++) begin
      int n, r, c;
      logic [31:0] v;
      n = $urandom_range(3); r = $urandom_range(rows - 1); c = $urandom_range(cols - 1);
      v = (kind == 3) ? mat[n][r][c] : {16'h0, mat[n][r][c][15:0]};
      el_check(n, r, c, v, {"R12 ", tag});
    end
    if (kind == 0) el_check(2, 3, 6, 32'h0, "R9");
    if (kind == 1) el_check(1, 5, 0, 32'h0, "R9");
  endtask

  initial begin
    #(20 * 150000);
    check(1'b0, "WATCHDOG", "run did not finish", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    cfg_kind = 2'd0; cfg_col_major = 1'b0;
    wr_valid = 1'b0; wr_comp = '0; wr_row = '0; wr_col = '0; wr_data = '0;
    flush = 1'b0; rd_req = 1'b0; rd_lane = '0;
    el_req = 1'b0; el_comp = '0; el_row = '0; el_col = '0;
    repeat (3) @(negedge clk);
    check(rd_vld == 1'b0, "R13", "rd_vld in reset", 32'(rd_vld), 32'd0);
    check(el_vld == 1'b0, "R13", "el_vld in reset", 32'(el_vld), 32'd0);
    check(img_done == 1'b0, "R13", "img_done in reset", 32'(img_done), 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(wr_ready == 1'b1, "R10", "ready when idle", 32'(wr_ready), 32'd1);
    run_mode(0, 1'b0, "R2/R1/R8/R9");
    run_mode(0, 1'b1, "R3/R1/R8");
    run_mode(1, 1'b0, "R4/R1/R8/R9");
    run_mode(1, 1'b1, "R5/R1/R8");
    run_mode(2, 1'b1, "R6/R1/R8");
    run_mode(3, 1'b0, "R7/R1/R11");
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule